// File: doc/BRIEF.md
# On-chip memory power-mode controller

This block drives the power controls of one on-chip SRAM and one on-chip ROM from the system's current low-power state. For each memory it produces three outputs: a chip select, a periphery power enable and a core-array power enable. It also reports the memory's present mode and a flag that marks access as blocked.

In the normal system state, the memory runs while an access is pending and otherwise falls back to Stand-by. The idle state, and deep-idle while the always-on domain stays on, both freeze the mode that was last chosen in normal. Two programmed fields set the deep-idle-off target and the stop / deep-stop target. Sleep always powers the memory down.

The enables never move together. Each change steps one enable per clock. Power-down takes the chip select, then the periphery, then the core. Wake-up restores the core, then the periphery, and only then the chip select. The ROM has no retention mode, so a retention setting falls back to Stand-by for it.

Top module: `mem_pwr_ctrl`

## Requirements
- R1: Synchronous reset leaves each memory in Stand-by: chip select 0, periphery 1, core 1, mode code 01, blocked 0. The held normal-state mode resets to Stand-by.
- R2: The system state code is 3'd0 normal, 3'd1 idle, 3'd2 deep-idle with the domain on, 3'd3 deep-idle with the domain off, 3'd4 stop, 3'd5 deep-stop, 3'd6 sleep and 3'd7 reserved. In normal state the target is Run when the access request is high and Stand-by when it is low. A request seen at one edge gives chip select high after that edge.
- R3: In idle (1) and deep-idle-on (2), the target is the mode chosen in the last normal cycle, and the access request has no effect.
- R4: In deep-idle-off (3), the target comes from the deep-idle field. The field encodes 2'b00 Stand-by, 2'b01 Retention, 2'b10 Power-down, and 2'b11 reserved, which is treated as Stand-by. The stop field is ignored in this state.
- R5: In stop (4) and deep-stop (5), the target comes from the stop field, with the same encoding.
- R6: In sleep (6) and in the reserved code (7), the target is Power-down whatever the fields hold.
- R7: For the ROM, a Retention setting selects Stand-by, so the ROM never rests with its periphery off and its core on.
- R8: Lowering changes one enable per clock, in the order chip select, then periphery, then core.
- R9: Raising changes one enable per clock, in the order core, then periphery, then chip select.
- R10: The blocked flag is high exactly while the periphery enable is low. That covers the span from the periphery drop until wake-up has restored it.
- R11: The mode code is 00 Run (chip select on), 01 Stand-by (periphery on, chip select off), 10 Retention (only the core on) and 11 Power-down (all off).
- R12: Chip select is only ever high with the periphery on, and the periphery is only ever on with the core on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_state_i | input | 3 | System low-power state code |
| acc_req_i | input | 1 | Access pending this cycle |
| dip_cfg_i | input | 2 | Target setting for deep-idle with domain off |
| stop_cfg_i | input | 2 | Target setting for stop and deep-stop |
| ram_cs_o | output | 1 | SRAM chip select |
| ram_peri_en_o | output | 1 | SRAM periphery power enable |
| ram_core_en_o | output | 1 | SRAM core array power enable |
| ram_mode_o | output | 2 | SRAM mode code |
| ram_blocked_o | output | 1 | SRAM access blocked |
| rom_cs_o | output | 1 | ROM chip select |
| rom_peri_en_o | output | 1 | ROM periphery power enable |
| rom_core_en_o | output | 1 | ROM core array power enable |
| rom_mode_o | output | 2 | ROM mode code |
| rom_blocked_o | output | 1 | ROM access blocked |

## Verification
The bench builds the block with its default capability vector: the SRAM can retain and the ROM cannot. One retention setting therefore shows the SRAM stopping with only its core powered while the ROM, in the same cycles, only drops its chip select. With these defaults every path can be stepped enable by enable and checked in each intermediate cycle: Run to Power-down through stop, the full wake-up, the reserved deep-idle code and sleep. The bench also exercises the frozen idle mode, with and without a pending request.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    localparam int CFG_W   = 2;
    localparam int STATE_W = 3;
    localparam int MODE_W  = 2;

    typedef enum logic [STATE_W-1:0] {
        SYS_NORMAL    = 3'd0,
        SYS_IDLE      = 3'd1,
        SYS_DIDLE_ON  = 3'd2,
        SYS_DIDLE_OFF = 3'd3,
        SYS_STOP      = 3'd4,
        SYS_DSTOP     = 3'd5,
        SYS_SLEEP     = 3'd6,
        SYS_RSVD      = 3'd7
    } sys_state_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_RUN  = 2'd0,
        MODE_STBY = 2'd1,
        MODE_RET  = 2'd2,
        MODE_PD   = 2'd3
    } mem_mode_e;

    typedef struct packed {
        logic cs;
        logic peri;
        logic core;
    } pwr_en_t;

    localparam pwr_en_t EN_STBY = '{cs: 1'b0, peri: 1'b1, core: 1'b1};

    // Decode a programmed target field; retention falls back when absent.
    function automatic mem_mode_e cfg_to_mode(input logic [CFG_W-1:0] cfg,
                                              input logic ret_ok);
        case (cfg)
            2'b01:   return ret_ok ? MODE_RET : MODE_STBY;
            2'b10:   return MODE_PD;
            default: return MODE_STBY;
        endcase
    endfunction

    function automatic pwr_en_t mode_to_en(input mem_mode_e m);
        case (m)
            MODE_RUN:  return '{cs: 1'b1, peri: 1'b1, core: 1'b1};
            MODE_STBY: return '{cs: 1'b0, peri: 1'b1, core: 1'b1};
            MODE_RET:  return '{cs: 1'b0, peri: 1'b0, core: 1'b1};
            default:   return '{cs: 1'b0, peri: 1'b0, core: 1'b0};
        endcase
    endfunction

    function automatic mem_mode_e en_to_mode(input pwr_en_t e);
        if (e.cs)        return MODE_RUN;
        else if (e.peri) return MODE_STBY;
        else if (e.core) return MODE_RET;
        else             return MODE_PD;
    endfunction

endpackage

// File: rtl/mpc_target.sv
module mpc_target
    import mpc_pkg::*;
#(
    parameter bit RET_OK = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  sys_state_e       state_i,
    input  logic             acc_req_i,
    input  logic [CFG_W-1:0] dip_cfg_i,
    input  logic [CFG_W-1:0] stop_cfg_i,
    output mem_mode_e        tgt_o
);

    mem_mode_e norm_q;
    mem_mode_e norm_now;

    assign norm_now = acc_req_i ? MODE_RUN : MODE_STBY;

    // Mode last chosen in normal state, frozen while idling.
    always_ff @(posedge clk) begin
        if (rst)
            norm_q <= MODE_STBY;
        else if (state_i == SYS_NORMAL)
            norm_q <= norm_now;
    end

    always_comb begin
        case (state_i)
            SYS_NORMAL:              tgt_o = norm_now;
            SYS_IDLE, SYS_DIDLE_ON:  tgt_o = norm_q;
            SYS_DIDLE_OFF:           tgt_o = cfg_to_mode(dip_cfg_i, RET_OK);
            SYS_STOP, SYS_DSTOP:     tgt_o = cfg_to_mode(stop_cfg_i, RET_OK);
            default:                 tgt_o = MODE_PD;
        endcase
    end

endmodule

// File: rtl/mpc_seq.sv
module mpc_seq
    import mpc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  mem_mode_e tgt_i,
    output pwr_en_t   en_o,
    output mem_mode_e mode_o,
    output logic      blocked_o
);

    pwr_en_t en_q;
    pwr_en_t want;

    assign want = mode_to_en(tgt_i);

    // One enable moves per clock: lowering cs->peri->core, raising core->peri->cs.
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= EN_STBY;
        else if (en_q.cs && !want.cs)
            en_q.cs <= 1'b0;
        else if (en_q.peri && !want.peri)
            en_q.peri <= 1'b0;
        else if (en_q.core && !want.core)
            en_q.core <= 1'b0;
        else if (!en_q.core && want.core)
            en_q.core <= 1'b1;
        else if (!en_q.peri && want.peri)
            en_q.peri <= 1'b1;
        else if (!en_q.cs && want.cs)
            en_q.cs <= 1'b1;
    end

    assign en_o      = en_q;
    assign mode_o    = en_to_mode(en_q);
    assign blocked_o = !en_q.peri;

    p_cs_needs_peri_r12: assert property (@(posedge clk) disable iff (rst)
        en_q.cs |-> en_q.peri);

    p_peri_needs_core_r12: assert property (@(posedge clk) disable iff (rst)
        en_q.peri |-> en_q.core);

    p_single_step_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(3'(en_q) ^ 3'($past(en_q))) <= 1);

endmodule

// File: rtl/mem_pwr_ctrl.sv
module mem_pwr_ctrl
    import mpc_pkg::*;
#(
    parameter logic [1:0] RET_CAP = 2'b01
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       sys_state_i,
    input  logic             acc_req_i,
    input  logic [1:0]       dip_cfg_i,
    input  logic [1:0]       stop_cfg_i,
    output logic             ram_cs_o,
    output logic             ram_peri_en_o,
    output logic             ram_core_en_o,
    output logic [1:0]       ram_mode_o,
    output logic             ram_blocked_o,
    output logic             rom_cs_o,
    output logic             rom_peri_en_o,
    output logic             rom_core_en_o,
    output logic [1:0]       rom_mode_o,
    output logic             rom_blocked_o
);

    localparam int NUM_MEM = 2;

    sys_state_e state;
    assign state = sys_state_e'(sys_state_i);

    pwr_en_t   en   [NUM_MEM];
    mem_mode_e mode [NUM_MEM];
    logic [NUM_MEM-1:0] blk;

    for (genvar g = 0; g < NUM_MEM; g++) begin : g_mem
        mem_mode_e tgt;

        mpc_target #(.RET_OK(RET_CAP[g])) u_tgt (
            .clk        (clk),
            .rst        (rst),
            .state_i    (state),
            .acc_req_i  (acc_req_i),
            .dip_cfg_i  (dip_cfg_i),
            .stop_cfg_i (stop_cfg_i),
            .tgt_o      (tgt)
        );

        mpc_seq u_seq (
            .clk       (clk),
            .rst       (rst),
            .tgt_i     (tgt),
            .en_o      (en[g]),
            .mode_o    (mode[g]),
            .blocked_o (blk[g])
        );
    end

    assign ram_cs_o      = en[0].cs;
    assign ram_peri_en_o = en[0].peri;
    assign ram_core_en_o = en[0].core;
    assign ram_mode_o    = mode[0];
    assign ram_blocked_o = blk[0];
    assign rom_cs_o      = en[1].cs;
    assign rom_peri_en_o = en[1].peri;
    assign rom_core_en_o = en[1].core;
    assign rom_mode_o    = mode[1];
    assign rom_blocked_o = blk[1];

    // Count consecutive sleep cycles (saturating) for the sleep check.
    logic [1:0] sleep_cnt;
    always_ff @(posedge clk) begin
        if (rst || sys_state_i != 3'd6)
            sleep_cnt <= '0;
        else if (sleep_cnt != 2'd3)
            sleep_cnt <= sleep_cnt + 2'd1;
    end

    p_sleep_off_r6: assert property (@(posedge clk) disable iff (rst)
        (sleep_cnt == 2'd3) |-> (!ram_core_en_o && !rom_core_en_o));

    p_rom_no_ret_r7: assert property (@(posedge clk) disable iff (rst)
        (!rom_peri_en_o && rom_core_en_o) |=> (!rom_core_en_o || rom_peri_en_o));

    p_cs_blocked_r10: assert property (@(posedge clk) disable iff (rst)
        ram_cs_o |-> !ram_blocked_o);

endmodule

// File: tb/mem_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module mem_pwr_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sys_state = 3'd0;
    logic       acc_req = 1'b0;
    logic [1:0] dip_cfg = 2'b00;
    logic [1:0] stop_cfg = 2'b00;
    logic       ram_cs, ram_p, ram_c, ram_b, rom_cs, rom_p, rom_c, rom_b;
    logic [1:0] ram_m, rom_m;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #4 clk = ~clk;

    mem_pwr_ctrl u_mem_pwr_ctrl (
        .clk(clk), .rst(rst), .sys_state_i(sys_state), .acc_req_i(acc_req),
        .dip_cfg_i(dip_cfg), .stop_cfg_i(stop_cfg),
        .ram_cs_o(ram_cs), .ram_peri_en_o(ram_p), .ram_core_en_o(ram_c),
        .ram_mode_o(ram_m), .ram_blocked_o(ram_b),
        .rom_cs_o(rom_cs), .rom_peri_en_o(rom_p), .rom_core_en_o(rom_c),
        .rom_mode_o(rom_m), .rom_blocked_o(rom_b)
    );

    // Expected {cs,peri,core,mode,blocked} from the enable triple (R10, R11).
    function automatic logic [5:0] expv(input logic [2:0] e);
        logic [1:0] m;
        if (e[2])      m = 2'b00;
        else if (e[1]) m = 2'b01;
        else if (e[0]) m = 2'b10;
        else           m = 2'b11;
        return {e, m, !e[1]};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [2:0] ram_e, input logic [2:0] rom_e);
        logic [5:0] a_ram = {ram_cs, ram_p, ram_c, ram_m, ram_b};
        logic [5:0] a_rom = {rom_cs, rom_p, rom_c, rom_m, rom_b};
        n_chk++;
        if (a_ram !== expv(ram_e) || a_rom !== expv(rom_e)) begin
            n_fail++;
            $display("FAIL %s: ram act=%b exp=%b rom act=%b exp=%b",
                     req, a_ram, expv(ram_e), a_rom, expv(rom_e));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        chk("R1 reset", 3'b011, 3'b011);
    endtask

    task automatic t_normal();
        sys_state = 3'd0; acc_req = 1'b1; tick();
        chk("R2 run on request", 3'b111, 3'b111);
        acc_req = 1'b0; tick();
        chk("R2 standby no request", 3'b011, 3'b011);
    endtask

    task automatic t_idle_hold();
        acc_req = 1'b1; tick();
        sys_state = 3'd1; acc_req = 1'b0; tick();
        chk("R3 idle holds run", 3'b111, 3'b111);
        sys_state = 3'd2; tick();
        chk("R3 deep-idle-on holds run", 3'b111, 3'b111);
        sys_state = 3'd0; tick();
        chk("R3 back to standby", 3'b011, 3'b011);
        sys_state = 3'd1; acc_req = 1'b1; tick();
        chk("R3 request ignored in idle", 3'b011, 3'b011);
        tick();
        chk("R3 request ignored in idle 2", 3'b011, 3'b011);
        acc_req = 1'b0;
    endtask

    task automatic t_stop_pd();
        sys_state = 3'd0; acc_req = 1'b1; tick();
        chk("R2 run before stop", 3'b111, 3'b111);
        sys_state = 3'd4; stop_cfg = 2'b10; acc_req = 1'b0; tick();
        chk("R8 R5 cs drops first", 3'b011, 3'b011);
        tick();
        chk("R8 periphery second", 3'b001, 3'b001);
        tick();
        chk("R8 core last", 3'b000, 3'b000);
        tick();
        chk("R5 power-down held", 3'b000, 3'b000);
    endtask

    task automatic t_wake();
        sys_state = 3'd0; acc_req = 1'b1; tick();
        chk("R9 core first", 3'b001, 3'b001);
        tick();
        chk("R9 periphery second", 3'b011, 3'b011);
        tick();
        chk("R9 cs last", 3'b111, 3'b111);
    endtask

    task automatic t_retention();
        sys_state = 3'd5; stop_cfg = 2'b01; acc_req = 1'b0; tick();
        chk("R5 deep-stop cs drop", 3'b011, 3'b011);
        tick();
        chk("R7 ram retains rom standby", 3'b001, 3'b011);
        tick();
        chk("R7 retention held", 3'b001, 3'b011);
        sys_state = 3'd0; tick();
        chk("R9 periphery back", 3'b011, 3'b011);
    endtask

    task automatic t_dip();
        sys_state = 3'd3; dip_cfg = 2'b10; stop_cfg = 2'b00; tick();
        chk("R4 dip pd periphery", 3'b001, 3'b001);
        tick();
        chk("R4 dip pd core", 3'b000, 3'b000);
        dip_cfg = 2'b11; stop_cfg = 2'b10; tick();
        chk("R4 reserved to standby step", 3'b001, 3'b001);
        tick();
        chk("R4 reserved standby, stop field ignored", 3'b011, 3'b011);
        tick();
        chk("R4 standby held", 3'b011, 3'b011);
    endtask

    task automatic t_sleep();
        sys_state = 3'd6; dip_cfg = 2'b00; stop_cfg = 2'b00; tick();
        chk("R6 sleep periphery", 3'b001, 3'b001);
        tick();
        chk("R6 sleep core", 3'b000, 3'b000);
        sys_state = 3'd7; tick();
        chk("R6 reserved code stays off", 3'b000, 3'b000);
        sys_state = 3'd0; acc_req = 1'b0; tick();
        chk("R9 wake core", 3'b001, 3'b001);
        tick();
        chk("R12 standby restored", 3'b011, 3'b011);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_normal();
        t_idle_hold();
        t_stop_pd();
        t_wake();
        t_retention();
        t_dip();
        t_sleep();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule